// File: doc/BRIEF.md
# Line Buffer Partition Configuration Finder

This block picks a storage arrangement for the line buffer that feeds a vertical scaler. A single start pulse delivers the widths of the luma viewport, the chroma viewport and the output rectangle, a pixel depth code, an alpha flag, a 4:2:0 flag, and the vertical tap counts and rounded-up vertical scale ratios for luma and chroma. The block then works out, for each candidate arrangement, how many lines of luma and chroma the buffer can hold (its partition counts), and tests whether those counts cover the taps the filter needs at that ratio.

Candidates are tried in a fixed priority order, and the first that passes is reported together with its partition counts and a one-cycle done pulse. The largest arrangement, number 0, is the fallback; if even that fails, an error flag accompanies it. A force input skips the search and selects arrangement 0 at once. All divisions share one serial restoring divider, so the search costs a few hundred cycles at most, which suits a block that runs once per mode change.

Top module: `lbuf_cfg_search`

## Requirements
- R1: The luma line size is min(vp_width, out_width) and the chroma line size is min(vpc_width, out_width); a line size of 0 is used as 1.
- R2: depth_code selects bits per component 0→10, 1→8, 2→6, 3→12; the luma and chroma word counts per line are ceil(line_size × bpc / 72), and the alpha word count per line is ceil(luma_line_size / 6).
- R3: Arrangement sizes in words (luma, chroma, alpha): 1 = (816, 816, 984); 2 = (1088, 1088, 1312); 3 = (4448, 1904, 2752); 0 = (2752, 2752, 2752). cfg_sel carries the arrangement number in binary.
- R4: Each partition count is floor(size / words_per_line); with alpha_en high the alpha count replaces the luma count when smaller; both reported counts are clamped to 64.
- R5: An arrangement passes when, for luma and for chroma separately, taps ≤ partitions − ratio + 2 if ratio > 2, and taps ≤ partitions otherwise (using the clamped counts).
- R6: Arrangements are tried in the order 1, 2, 3, 0, with 3 skipped unless is_420 is high; the first passing one is reported with its counts.
- R7: When the search reaches arrangement 0 and it fails, arrangement 0 is still reported with its counts and cfg_err high; cfg_err is low for every passing result.
- R8: A start with force_max high gives done in the next cycle with cfg_sel 0, both counts 0 and cfg_err 0, and busy stays low.
- R9: After an unforced start, busy is high from the next cycle until the cycle of the done pulse, in which busy is low; done lasts one cycle and the results hold until the next start.
- R10: A start pulse while busy is high is ignored: the result reflects the inputs of the accepted start.
- R11: After reset, busy, done, cfg_sel, both counts and cfg_err are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search with the inputs present in this cycle |
| force_max | input | 1 | Select arrangement 0 without searching |
| vp_width | input | WID_W | Luma viewport width in pixels |
| vpc_width | input | WID_W | Chroma viewport width in pixels |
| out_width | input | WID_W | Output rectangle width in pixels |
| depth_code | input | 2 | Stored pixel depth code |
| alpha_en | input | 1 | Alpha stored in the buffer |
| is_420 | input | 1 | Source is 4:2:0 subsampled |
| vtaps_y | input | TAP_W | Luma vertical taps |
| vtaps_c | input | TAP_W | Chroma vertical taps |
| ratio_y | input | TAP_W | Rounded-up luma vertical ratio |
| ratio_c | input | TAP_W | Rounded-up chroma vertical ratio |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| cfg_sel | output | 2 | Selected arrangement number |
| parts_y | output | PART_W | Luma partition count of the result |
| parts_c | output | PART_W | Chroma partition count of the result |
| cfg_err | output | 1 | Fallback arrangement also fails |

## Verification
Assertions watch the handshake on every cycle: the done strobe never lasts two cycles, busy only falls together with done, reported counts never exceed 64, the error flag only appears with arrangement 0, arrangement 3 never appears for non-4:2:0 input, and every quotient from the divider satisfies quotient × divisor + remainder = dividend. Whether the chosen arrangement and its counts are the right ones depends on the whole chain of line size, depth, memory size, alpha replacement and the ratio-dependent tap rule, which only the bench's sweep over widths, depths, flags and tap/ratio sets against an arithmetic model can show, together with the forced path and the ignored start.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

  localparam int MEM_W = 13;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_DIV,
    ST_WAIT,
    ST_CHECK
  } lbc_state_t;

  // kind: 0 luma, 1 chroma, 2 alpha
  function automatic logic [MEM_W-1:0] mem_words(input logic [1:0] cfg, input logic [1:0] kind);
    logic [MEM_W-1:0] w;
    case (cfg)
      2'd1: w = (kind == 2'd2) ? MEM_W'(984) : MEM_W'(816);
      2'd2: w = (kind == 2'd2) ? MEM_W'(1312) : MEM_W'(1088);
      2'd3: w = (kind == 2'd0) ? MEM_W'(4448) : (kind == 2'd1) ? MEM_W'(1904) : MEM_W'(2752);
      default: w = MEM_W'(2752);
    endcase
    return w;
  endfunction

endpackage

// File: rtl/lbc_linesize.sv
module lbc_linesize #(
  parameter int WID_W = 14,
  parameter int DIV_W = 13
) (
  input  logic [WID_W-1:0] vp_w,
  input  logic [WID_W-1:0] vpc_w,
  input  logic [WID_W-1:0] out_w,
  input  logic [1:0]       depth,
  output logic [DIV_W-1:0] words_y,
  output logic [DIV_W-1:0] words_c,
  output logic [DIV_W-1:0] words_a
);
  localparam int PROD_W = WID_W + 4;

  logic [WID_W-1:0]  len_y, len_c;
  logic [3:0]        bpc;
  logic [PROD_W-1:0] prod_y, prod_c;
  logic [WID_W:0]    alen;

  always_comb begin
    len_y = (vp_w < out_w) ? vp_w : out_w;
    len_c = (vpc_w < out_w) ? vpc_w : out_w;
    if (len_y == '0) len_y = WID_W'(1);
    if (len_c == '0) len_c = WID_W'(1);
    case (depth)
      2'd0: bpc = 4'd10;
      2'd1: bpc = 4'd8;
      2'd2: bpc = 4'd6;
      default: bpc = 4'd12;
    endcase
    prod_y = PROD_W'(len_y) * PROD_W'(bpc) + PROD_W'(71);
    prod_c = PROD_W'(len_c) * PROD_W'(bpc) + PROD_W'(71);
    alen   = (WID_W+1)'(len_y) + (WID_W+1)'(5);
    words_y = DIV_W'(prod_y / PROD_W'(72));
    words_c = DIV_W'(prod_c / PROD_W'(72));
    words_a = DIV_W'(alen / (WID_W+1)'(6));
  end
endmodule

// File: rtl/lbc_divider.sv
module lbc_divider #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         done
);
  localparam int CNT_W = $clog2(W) + 1;
  localparam int PW    = 2 * W;

  logic [W-1:0]     dvd_q, dsr_q;
  logic [CNT_W-1:0] cnt;
  logic             run;
  logic [W:0]       partial;
  logic             take;

  always_comb begin
    partial = {remainder, quotient[W-1]};
    take    = partial >= {1'b0, dsr_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quotient  <= '0;
      remainder <= '0;
      dvd_q     <= '0;
      dsr_q     <= '0;
      cnt       <= '0;
      run       <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        quotient  <= dividend;
        remainder <= '0;
        dvd_q     <= dividend;
        dsr_q     <= divisor;
        cnt       <= '0;
        run       <= 1'b1;
      end else if (run) begin
        remainder <= take ? W'(partial - {1'b0, dsr_q}) : partial[W-1:0];
        quotient  <= {quotient[W-2:0], take};
        cnt       <= cnt + 1'b1;
        if (cnt == CNT_W'(W-1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R4
  div_exact_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (PW'(quotient) * PW'(dsr_q) + PW'(remainder) == PW'(dvd_q)) && (remainder < dsr_q));

endmodule

// File: rtl/lbuf_cfg_search.sv
module lbuf_cfg_search
  import lbc_pkg::*;
#(
  parameter int WID_W    = 14,
  parameter int TAP_W    = 4,
  parameter int DIV_W    = 13,
  parameter int PART_W   = 7,
  parameter int PART_MAX = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              force_max,
  input  logic [WID_W-1:0]  vp_width,
  input  logic [WID_W-1:0]  vpc_width,
  input  logic [WID_W-1:0]  out_width,
  input  logic [1:0]        depth_code,
  input  logic              alpha_en,
  input  logic              is_420,
  input  logic [TAP_W-1:0]  vtaps_y,
  input  logic [TAP_W-1:0]  vtaps_c,
  input  logic [TAP_W-1:0]  ratio_y,
  input  logic [TAP_W-1:0]  ratio_c,
  output logic              busy,
  output logic              done,
  output logic [1:0]        cfg_sel,
  output logic [PART_W-1:0] parts_y,
  output logic [PART_W-1:0] parts_c,
  output logic              cfg_err
);
  localparam int CMP_W = ((PART_W > TAP_W) ? PART_W : TAP_W) + 2;

  lbc_state_t       st;
  logic [WID_W-1:0] vp_q, vpc_q, ow_q;
  logic [1:0]       depth_q;
  logic             alpha_q, f420_q;
  logic [TAP_W-1:0] ty_q, tc_q, ry_q, rc_q;
  logic [DIV_W-1:0] wy_c, wc_c, wa_c, wy_q, wc_q, wa_q;
  logic [1:0]       cfg_q, kind_q;
  logic [DIV_W-1:0] qy, qc, qa;
  logic             div_start, div_done;
  logic [DIV_W-1:0] div_num, div_den, div_quo, div_rem;
  logic [DIV_W-1:0] eff_y;
  logic [PART_W-1:0] cl_y, cl_c;
  logic             ok_y, ok_c, ok_all;
  logic [1:0]       cfg_next;

  function automatic logic fits(input logic [PART_W-1:0] p, input logic [TAP_W-1:0] t,
                                input logic [TAP_W-1:0] r);
    logic [CMP_W-1:0] pe, te, re;
    pe = CMP_W'(p);
    te = CMP_W'(t);
    re = CMP_W'(r);
    if (re > CMP_W'(2)) return (te + re) <= (pe + CMP_W'(2));
    else                return te <= pe;
  endfunction

  function automatic logic [PART_W-1:0] clamp(input logic [DIV_W-1:0] v);
    return (v > DIV_W'(PART_MAX)) ? PART_W'(PART_MAX) : PART_W'(v);
  endfunction

  lbc_linesize #(.WID_W(WID_W), .DIV_W(DIV_W)) i_linesize (
    .vp_w(vp_q), .vpc_w(vpc_q), .out_w(ow_q), .depth(depth_q),
    .words_y(wy_c), .words_c(wc_c), .words_a(wa_c)
  );

  always_comb begin
    div_start = (st == ST_DIV);
    div_num   = DIV_W'(mem_words(cfg_q, kind_q));
    case (kind_q)
      2'd0:    div_den = wy_q;
      2'd1:    div_den = wc_q;
      default: div_den = wa_q;
    endcase
  end

  lbc_divider #(.W(DIV_W)) i_divider (
    .clk(clk), .rst(rst), .start(div_start), .dividend(div_num), .divisor(div_den),
    .quotient(div_quo), .remainder(div_rem), .done(div_done)
  );

  always_comb begin
    eff_y  = (alpha_q && (qa < qy)) ? qa : qy;
    cl_y   = clamp(eff_y);
    cl_c   = clamp(qc);
    ok_y   = fits(cl_y, ty_q, ry_q);
    ok_c   = fits(cl_c, tc_q, rc_q);
    ok_all = ok_y && ok_c;
    case (cfg_q)
      2'd1:    cfg_next = 2'd2;
      2'd2:    cfg_next = f420_q ? 2'd3 : 2'd0;
      default: cfg_next = 2'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
      {vp_q, vpc_q, ow_q} <= '0;
      depth_q <= '0;
      alpha_q <= 1'b0;
      f420_q  <= 1'b0;
      {ty_q, tc_q, ry_q, rc_q} <= '0;
      {wy_q, wc_q, wa_q} <= '0;
      cfg_q   <= '0;
      kind_q  <= '0;
      {qy, qc, qa} <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      cfg_sel <= '0;
      parts_y <= '0;
      parts_c <= '0;
      cfg_err <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start && force_max) begin
            done    <= 1'b1;
            cfg_sel <= 2'd0;
            parts_y <= '0;
            parts_c <= '0;
            cfg_err <= 1'b0;
          end else if (start) begin
            vp_q    <= vp_width;
            vpc_q   <= vpc_width;
            ow_q    <= out_width;
            depth_q <= depth_code;
            alpha_q <= alpha_en;
            f420_q  <= is_420;
            ty_q    <= vtaps_y;
            tc_q    <= vtaps_c;
            ry_q    <= ratio_y;
            rc_q    <= ratio_c;
            cfg_q   <= 2'd1;
            kind_q  <= 2'd0;
            qa      <= '0;
            busy    <= 1'b1;
            st      <= ST_PREP;
          end
        end
        ST_PREP: begin
          wy_q <= wy_c;
          wc_q <= wc_c;
          wa_q <= wa_c;
          st   <= ST_DIV;
        end
        ST_DIV: st <= ST_WAIT;
        ST_WAIT: begin
          if (div_done) begin
            case (kind_q)
              2'd0: begin qy <= div_quo; kind_q <= 2'd1; st <= ST_DIV; end
              2'd1: begin
                qc <= div_quo;
                if (alpha_q) begin kind_q <= 2'd2; st <= ST_DIV; end
                else st <= ST_CHECK;
              end
              default: begin qa <= div_quo; st <= ST_CHECK; end
            endcase
          end
        end
        ST_CHECK: begin
          if (ok_all || (cfg_q == 2'd0)) begin
            cfg_sel <= cfg_q;
            parts_y <= cl_y;
            parts_c <= cl_c;
            cfg_err <= !ok_all;
            done    <= 1'b1;
            busy    <= 1'b0;
            st      <= ST_IDLE;
          end else begin
            cfg_q  <= cfg_next;
            kind_q <= 2'd0;
            st     <= ST_DIV;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R9
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R4
  part_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (parts_y <= PART_W'(PART_MAX)) && (parts_c <= PART_W'(PART_MAX)));
  // R7
  err_cfg_chk: assert property (@(posedge clk) disable iff (rst) cfg_err |-> (cfg_sel == 2'd0));
  // R6
  no_cfg3_chk: assert property (@(posedge clk) disable iff (rst)
    (done && busy == 1'b0 && $past(busy) && !f420_q) |-> (cfg_sel != 2'd3));

endmodule

// File: tb/test_lbuf_cfg_search.sv
module test_lbuf_cfg_search;
  localparam int CLK_PERIOD = 10;
  localparam int WID_W = 14;
  localparam int TAP_W = 4;
  localparam int PART_W = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, force_max = 1'b0;
  logic [WID_W-1:0] vp_width = '0, vpc_width = '0, out_width = '0;
  logic [1:0] depth_code = '0;
  logic alpha_en = 1'b0, is_420 = 1'b0;
  logic [TAP_W-1:0] vtaps_y = '0, vtaps_c = '0, ratio_y = '0, ratio_c = '0;
  logic busy, done, cfg_err;
  logic [1:0] cfg_sel;
  logic [PART_W-1:0] parts_y, parts_c;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lbuf_cfg_search i_lbuf_cfg_search (
    .clk(clk), .rst(rst), .start(start), .force_max(force_max),
    .vp_width(vp_width), .vpc_width(vpc_width), .out_width(out_width),
    .depth_code(depth_code), .alpha_en(alpha_en), .is_420(is_420),
    .vtaps_y(vtaps_y), .vtaps_c(vtaps_c), .ratio_y(ratio_y), .ratio_c(ratio_c),
    .busy(busy), .done(done), .cfg_sel(cfg_sel), .parts_y(parts_y),
    .parts_c(parts_c), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Arithmetic model of R1..R7
  task automatic ref_model(input int vp, vpc, ow, dep, al, f4, ty, tc, ry, rc,
                           output int cfg, py, pc, err);
    int bpc, ly, lc, wy, wc, wa, sy, sc, sa, y, c, a, n;
    int ord[4];
    bit ok;
    bpc = (dep == 0) ? 10 : (dep == 1) ? 8 : (dep == 2) ? 6 : 12;
    ly = (vp < ow) ? vp : ow;  if (ly == 0) ly = 1;
    lc = (vpc < ow) ? vpc : ow; if (lc == 0) lc = 1;
    wy = (ly * bpc + 71) / 72;
    wc = (lc * bpc + 71) / 72;
    wa = (ly + 5) / 6;
    n = 0;
    ord[n++] = 1; ord[n++] = 2;
    if (f4 != 0) ord[n++] = 3;
    ord[n++] = 0;
    cfg = 0; py = 0; pc = 0; err = 0;
    for (int i = 0; i < n; i++) begin
      case (ord[i])
        1: begin sy = 816;  sc = 816;  sa = 984;  end
        2: begin sy = 1088; sc = 1088; sa = 1312; end
        3: begin sy = 816+1088+848*3; sc = 816+1088; sa = 984+1312+456; end
        default: begin sy = 816+1088+848; sc = sy; sa = 984+1312+456; end
      endcase
      y = sy / wy; c = sc / wc; a = sa / wa;
      if (al != 0 && a < y) y = a;
      if (y > 64) y = 64;
      if (c > 64) c = 64;
      ok = ((ry > 2) ? (ty <= y - ry + 2) : (ty <= y)) &&
           ((rc > 2) ? (tc <= c - rc + 2) : (tc <= c));
      if (ok || ord[i] == 0) begin
        cfg = ord[i]; py = y; pc = c; err = ok ? 0 : 1;
        return;
      end
    end
  endtask

  task automatic wait_done();
    int guard = 0;
    while (done !== 1'b1) begin
      @(negedge clk);
      guard++;
      if (guard > 2000) begin
        checks++;
        failures++;
        $display("FAIL R9 watchdog actual=%0d expected=%0d", 0, 1);
        finish_run();
      end
    end
  endtask

  task automatic run_one(input int vp, vpc, ow, dep, al, f4, ty, tc, ry, rc);
    int ecfg, epy, epc, eerr;
    ref_model(vp, vpc, ow, dep, al, f4, ty, tc, ry, rc, ecfg, epy, epc, eerr);
    @(negedge clk);
    vp_width = WID_W'(vp); vpc_width = WID_W'(vpc); out_width = WID_W'(ow);
    depth_code = 2'(dep); alpha_en = 1'(al); is_420 = 1'(f4);
    vtaps_y = TAP_W'(ty); vtaps_c = TAP_W'(tc); ratio_y = TAP_W'(ry); ratio_c = TAP_W'(rc);
    force_max = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 busy after start", int'(busy), 1);
    wait_done();
    // R1 R2 R3 R4 R5 R6
    chk("R6 cfg_sel", int'(cfg_sel), ecfg);
    chk("R4 parts_y", int'(parts_y), epy);
    chk("R4 parts_c", int'(parts_c), epc);
    // R7
    chk("R7 cfg_err", int'(cfg_err), eerr);
    @(negedge clk);
    chk("R9 done one cycle", int'(done), 0);
    chk("R9 result held", int'(cfg_sel), ecfg);
  endtask

  initial begin
    int widths[6];
    int tset[5][4];
    int ecfg, epy, epc, eerr;
    widths = '{0, 1, 640, 1920, 3840, 8000};
    tset = '{'{2,2,1,1}, '{4,2,1,2}, '{4,4,3,3}, '{6,4,4,2}, '{8,8,4,4}};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11
    chk("R11 busy", int'(busy), 0);
    chk("R11 done", int'(done), 0);
    chk("R11 cfg_sel", int'(cfg_sel), 0);
    chk("R11 parts_y", int'(parts_y), 0);
    chk("R11 parts_c", int'(parts_c), 0);
    chk("R11 cfg_err", int'(cfg_err), 0);

    // Sweep R1 R2 R3 R4 R5 R6 R7
    for (int wi = 0; wi < 6; wi++)
      for (int d = 0; d < 4; d++)
        for (int al = 0; al < 2; al++)
          for (int f4 = 0; f4 < 2; f4++)
            for (int t = 0; t < 5; t++) begin
              int w, ow;
              w  = widths[wi];
              ow = (w == 1920) ? 1280 : w;
              run_one(w, w / 2, ow, d, al, f4, tset[t][0], tset[t][1], tset[t][2], tset[t][3]);
            end

    // R1: chroma viewport wider than output, luma narrower
    run_one(500, 4000, 3000, 0, 0, 1, 4, 4, 1, 1);

    // R8: forced selection
    run_one(8000, 8000, 8000, 3, 1, 1, 8, 8, 4, 4);
    @(negedge clk);
    force_max = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    force_max = 1'b0;
    chk("R8 done next cycle", int'(done), 1);
    chk("R8 busy low", int'(busy), 0);
    chk("R8 cfg_sel", int'(cfg_sel), 0);
    chk("R8 parts_y", int'(parts_y), 0);
    chk("R8 parts_c", int'(parts_c), 0);
    chk("R8 cfg_err", int'(cfg_err), 0);

    // R10: second start during busy is ignored
    ref_model(3840, 1920, 3840, 0, 0, 1, 4, 4, 1, 1, ecfg, epy, epc, eerr);
    @(negedge clk);
    vp_width = 14'd3840; vpc_width = 14'd1920; out_width = 14'd3840;
    depth_code = 2'd0; alpha_en = 1'b0; is_420 = 1'b1;
    vtaps_y = 4'd4; vtaps_c = 4'd4; ratio_y = 4'd1; ratio_c = 4'd1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    vp_width = 14'd1; vpc_width = 14'd1; out_width = 14'd1;
    vtaps_y = 4'd2; vtaps_c = 4'd2; is_420 = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk("R10 cfg_sel", int'(cfg_sel), ecfg);
    chk("R10 parts_y", int'(parts_y), epy);
    chk("R10 parts_c", int'(parts_c), epc);
    repeat (3) @(negedge clk);
    chk("R10 no second done", int'(done), 0);
    chk("R10 idle", int'(busy), 0);

    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R9 global watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

endmodule